// File: doc/BRIEF.md
# Serial Flash Command Protection Gate

This block sits in front of a serial flash command engine and decides, for every requested command, whether the engine may carry it out. Each command arrives with an index into a small opcode-kind table and a byte address. The table marks every opcode slot as either a read kind or a write kind. The block then checks the command against three independent protection sources. The first is a set of write-protected address windows, each with its own enable. The second is a global write protect that an interrupt-driven override request can lift. The third is a shared window that refuses reads as well as writes. The command is refused when any one of the sources objects.

A refused command is not reported as an error and does not stall the engine. One cycle after the request, the block signals completion like any other command. It withholds the issue strobe, so nothing reaches the flash, and it raises a sticky status flag that software clears by writing a one to it. A one-way lock bit freezes the protected windows and the opcode-kind table until reset, so early boot code can fix the policy for the rest of the session.

Top module: `flash_guard`

## Requirements
- R1: A write-kind command is refused when its page (`cmdAddr[23:12]`) lies within an enabled protected window, with both ends inclusive. A window register at address 0..3 holds its base page in bits [11:0], its limit page in bits [23:12] and its enable in bit 31.
- R2: A protected window never refuses a read-kind command, and a disabled window refuses nothing. Opcode slot i is write kind when bit i of the table register at address 4 is 1.
- R3: When bit 0 (global protect) of the control register at address 5 is set, every write-kind command is refused. The one exception is a command made while `overrideReq` is high and bit 1 (override enable) is set. Read-kind commands are not affected.
- R4: The shared window register at address 6 uses the same layout as a protected window. When it is enabled, it refuses both reads and writes whose page falls within it.
- R5: A command is refused if any of the three sources objects. Otherwise it is issued.
- R6: Every request with `cmdValid` gives a `cmdDone` pulse exactly one cycle later. Together with that pulse comes either `cmdIssue` (allowed) or `cmdBlocked` (refused), never both.
- R7: A refused command sets the status flag. The flag is read at address 7 bit 0 and appears on `blockedFlag`. It stays set until a write with bit 0 = 1 to address 7. A write of 0 has no effect, and a new refusal in the same cycle as a clear leaves the flag set.
- R8: Bit 2 of the control register is the lock. Writing it as 1 sets it, and only reset clears it. While it is set, writes to addresses 0..4 are ignored and their read-back values do not change.
- R9: After reset all registers read 0 and `cmdDone`, `cmdIssue`, `cmdBlocked` and `blockedFlag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register address |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Read-back of the register at `cfgAddr` |
| cmdValid | input | 1 | Command request, one cycle |
| cmdOpIdx | input | 3 | Opcode slot of the command |
| cmdAddr | input | 24 | Byte address of the command |
| overrideReq | input | 1 | Interrupt-driven request to lift the global write protect |
| cmdIssue | output | 1 | Command may be sent to the flash |
| cmdDone | output | 1 | Command completion |
| cmdBlocked | output | 1 | Command was refused |
| blockedFlag | output | 1 | Sticky refused-command status |

## Verification
The bench probes the window edges: the first and last byte of the base and limit pages, and the bytes just outside them. A design that treats either end as exclusive, or compares whole byte addresses, would let a write through at an edge or refuse a neighbour. It covers the four combinations of override request and override enable, and a design that honours either signal alone would issue a write it should refuse. It also puts a refusal in the same cycle as a status clear, where a clear-wins design would lose the flag. Finally, it writes to a locked window, the locked table and the lock bit itself, and reads back unchanged values, which a design that only gates the enable field would fail.

// File: rtl/fguard_pkg.sv
package fguard_pkg;
  parameter int ADDR_W     = 24;
  parameter int PAGE_SHIFT = 12;
  parameter int NUM_RANGES = 4;
  parameter int NUM_OPS    = 8;
  parameter int DATA_W     = 32;

  localparam int PAGE_W  = ADDR_W - PAGE_SHIFT;
  localparam int OP_W    = $clog2(NUM_OPS);
  localparam int REG_CNT = NUM_RANGES + 4;
  localparam int CFG_AW  = $clog2(REG_CNT);
  localparam int EN_BIT  = DATA_W - 1;

  typedef struct packed {
    logic              en;
    logic [PAGE_W-1:0] limitPg;
    logic [PAGE_W-1:0] basePg;
  } window_t;

  typedef struct packed {
    logic [NUM_RANGES-1:0] wrRange;
    logic                  wrOps;
    logic                  wrCtl;
    logic                  wrShare;
    logic                  clrStat;
    logic                  setStat;
  } strobe_t;

  function automatic window_t toWindow(input logic [DATA_W-1:0] d);
    window_t w;
    w.en      = d[EN_BIT];
    w.limitPg = d[2*PAGE_W-1:PAGE_W];
    w.basePg  = d[PAGE_W-1:0];
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] fromWindow(input window_t w);
    logic [DATA_W-1:0] d;
    d = '0;
    d[EN_BIT] = w.en;
    d[2*PAGE_W-1:PAGE_W] = w.limitPg;
    d[PAGE_W-1:0] = w.basePg;
    return d;
  endfunction

  function automatic logic pageInside(input window_t w, input logic [PAGE_W-1:0] pg);
    return w.en && (pg >= w.basePg) && (pg <= w.limitPg);
  endfunction
endpackage

// File: rtl/fguard_ctrl.sv
module fguard_ctrl
  import fguard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              cfgBit0,
  input  logic              lockQ,
  input  logic              cmdValid,
  input  logic              blockNow,
  output strobe_t           stb,
  output logic              cmdIssue,
  output logic              cmdDone,
  output logic              cmdBlocked
);
  localparam logic [CFG_AW-1:0] OPS_A   = CFG_AW'(NUM_RANGES);
  localparam logic [CFG_AW-1:0] CTL_A   = CFG_AW'(NUM_RANGES + 1);
  localparam logic [CFG_AW-1:0] SHARE_A = CFG_AW'(NUM_RANGES + 2);
  localparam logic [CFG_AW-1:0] STAT_A  = CFG_AW'(NUM_RANGES + 3);

  for (genvar g = 0; g < NUM_RANGES; g++) begin : gWinStb
    assign stb.wrRange[g] = cfgWe && (cfgAddr == CFG_AW'(g)) && !lockQ;
  end

  assign stb.wrOps   = cfgWe && (cfgAddr == OPS_A) && !lockQ;
  assign stb.wrCtl   = cfgWe && (cfgAddr == CTL_A);
  assign stb.wrShare = cfgWe && (cfgAddr == SHARE_A);
  assign stb.clrStat = cfgWe && (cfgAddr == STAT_A) && cfgBit0;
  assign stb.setStat = cmdValid && blockNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdDone    <= 1'b0;
      cmdIssue   <= 1'b0;
      cmdBlocked <= 1'b0;
    end else begin
      cmdDone    <= cmdValid;
      cmdIssue   <= cmdValid && !blockNow;
      cmdBlocked <= cmdValid && blockNow;
    end
  end

  a_r6_done_follows: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> cmdDone);
  a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |-> (cmdIssue ^ cmdBlocked));
  a_r6_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !cmdDone |-> (!cmdIssue && !cmdBlocked));
endmodule

// File: rtl/fguard_dp.sv
module fguard_dp
  import fguard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic [OP_W-1:0]   cmdOpIdx,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              overrideReq,
  output logic [DATA_W-1:0] cfgRdata,
  output logic              lockQ,
  output logic              blockNow,
  output logic              statusQ
);
  window_t [NUM_RANGES-1:0] winQ;
  window_t                  shareQ;
  logic [NUM_OPS-1:0]       opKindQ;
  logic                     gwpQ;
  logic                     ovrEnQ;

  logic [PAGE_W-1:0]     cmdPage;
  logic [NUM_RANGES-1:0] winHit;
  logic                  isWrite;
  logic                  rangeBlk;
  logic                  globalBlk;
  logic                  shareBlk;
  logic                  unusedDp;

  assign cmdPage  = cmdAddr[ADDR_W-1:PAGE_SHIFT];
  assign unusedDp = ^{cmdAddr[PAGE_SHIFT-1:0], cfgWdata[EN_BIT-1:2*PAGE_W]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winQ    <= '0;
      shareQ  <= '0;
      opKindQ <= '0;
      gwpQ    <= 1'b0;
      ovrEnQ  <= 1'b0;
      lockQ   <= 1'b0;
      statusQ <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_RANGES; i++) begin
        if (stb.wrRange[i]) winQ[i] <= toWindow(cfgWdata);
      end
      if (stb.wrOps) opKindQ <= cfgWdata[NUM_OPS-1:0];
      if (stb.wrShare) shareQ <= toWindow(cfgWdata);
      if (stb.wrCtl) begin
        gwpQ   <= cfgWdata[0];
        ovrEnQ <= cfgWdata[1];
        lockQ  <= lockQ | cfgWdata[2];
      end
      if (stb.setStat) statusQ <= 1'b1;
      else if (stb.clrStat) statusQ <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_RANGES; g++) begin : gWinCmp
    assign winHit[g] = pageInside(winQ[g], cmdPage);
  end

  assign isWrite   = opKindQ[cmdOpIdx];
  assign rangeBlk  = isWrite && (|winHit);
  assign globalBlk = isWrite && gwpQ && !(overrideReq && ovrEnQ);
  assign shareBlk  = pageInside(shareQ, cmdPage);
  assign blockNow  = rangeBlk || globalBlk || shareBlk;

  always_comb begin
    cfgRdata = '0;
    if (cfgAddr < CFG_AW'(NUM_RANGES)) begin
      cfgRdata = fromWindow(winQ[cfgAddr[$clog2(NUM_RANGES)-1:0]]);
    end else if (cfgAddr == CFG_AW'(NUM_RANGES)) begin
      cfgRdata[NUM_OPS-1:0] = opKindQ;
    end else if (cfgAddr == CFG_AW'(NUM_RANGES + 1)) begin
      cfgRdata[2:0] = {lockQ, ovrEnQ, gwpQ};
    end else if (cfgAddr == CFG_AW'(NUM_RANGES + 2)) begin
      cfgRdata = fromWindow(shareQ);
    end else begin
      cfgRdata[0] = statusQ;
    end
  end

  a_r8_lock_kept: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);
  a_r8_ops_frozen: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> $stable(opKindQ));
  a_r8_wins_frozen: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> $stable(winQ));
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ && !stb.clrStat) |=> statusQ);
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    stb.setStat |=> statusQ);
  a_r4_share_refuses: assert property (@(posedge clk) disable iff (!rstN)
    shareBlk |-> blockNow);
  a_r2_reads_pass_windows: assert property (@(posedge clk) disable iff (!rstN)
    (!isWrite && !shareBlk) |-> !blockNow);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fguard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  output logic [DATA_W-1:0] cfgRdata,
  input  logic              cmdValid,
  input  logic [OP_W-1:0]   cmdOpIdx,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              overrideReq,
  output logic              cmdIssue,
  output logic              cmdDone,
  output logic              cmdBlocked,
  output logic              blockedFlag
);
  strobe_t stb;
  logic    lockQ;
  logic    blockNow;

  fguard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgBit0(cfgWdata[0]), .lockQ(lockQ), .cmdValid(cmdValid),
    .blockNow(blockNow), .stb(stb), .cmdIssue(cmdIssue),
    .cmdDone(cmdDone), .cmdBlocked(cmdBlocked)
  );

  fguard_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cmdOpIdx(cmdOpIdx), .cmdAddr(cmdAddr),
    .overrideReq(overrideReq), .cfgRdata(cfgRdata), .lockQ(lockQ),
    .blockNow(blockNow), .statusQ(blockedFlag)
  );

  a_r7_flag_on_refusal: assert property (@(posedge clk) disable iff (!rstN)
    cmdBlocked |-> blockedFlag);
endmodule

// File: tb/flash_guard_tb.sv
`timescale 1ns/1ps
module flash_guard_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOpIdx = '0;
  logic [23:0] cmdAddr = '0;
  logic        overrideReq = 1'b0;
  logic        cmdIssue, cmdDone, cmdBlocked, blockedFlag;

  int checks = 0;
  int errors = 0;
  bit    expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  flash_guard u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .cmdValid(cmdValid),
    .cmdOpIdx(cmdOpIdx), .cmdAddr(cmdAddr), .overrideReq(overrideReq),
    .cmdIssue(cmdIssue), .cmdDone(cmdDone), .cmdBlocked(cmdBlocked),
    .blockedFlag(blockedFlag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgCheck(input string tag, input logic [2:0] a, input logic [31:0] exp);
    cfgAddr = a;
    #1;
    check(tag, cfgRdata, exp);
  endtask

  task automatic sendCmd(input logic [2:0] op, input logic [23:0] a, input logic ovr,
                         input bit expBlk, input string tag);
    @(negedge clk);
    cmdValid = 1'b1; cmdOpIdx = op; cmdAddr = a; overrideReq = ovr;
    expQ.push_back(expBlk); tagQ.push_back(tag);
    @(negedge clk);
    cmdValid = 1'b0; overrideReq = 1'b0;
  endtask

  // Monitor: every completion pops one expected outcome (R6)
  always @(negedge clk) begin
    if (rstN && cmdDone) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 unexpected completion actual=1 expected=0");
      end else begin
        bit    e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({t, " R6 blocked"}, {31'b0, cmdBlocked}, {31'b0, e});
        check({t, " R6 issue"}, {31'b0, cmdIssue}, {31'b0, !e});
      end
    end
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 done", {31'b0, cmdDone}, 32'h0);
    check("R9 flag", {31'b0, blockedFlag}, 32'h0);
    cfgCheck("R9 window0", 3'd0, 32'h0);
    cfgCheck("R9 ctl", 3'd5, 32'h0);
    rstN = 1'b1;

    cfgWrite(3'd4, 32'h0000_0006);           // slots 1,2 are write kind
    cfgWrite(3'd0, 32'h8001_F010);           // pages 0x010..0x01F, enabled
    cfgWrite(3'd1, 32'h001F_F100);           // pages 0x100..0x1FF, disabled
    cfgCheck("R1 window0 readback", 3'd0, 32'h8001_F010);

    // R1 edges
    sendCmd(3'd1, 24'h010000, 1'b0, 1'b1, "R1 base edge");
    sendCmd(3'd2, 24'h01FFFF, 1'b0, 1'b1, "R1 limit edge");
    sendCmd(3'd1, 24'h020000, 1'b0, 1'b0, "R1 above limit");
    sendCmd(3'd1, 24'h00FFFF, 1'b0, 1'b0, "R1 below base");
    // R2 reads and disabled window
    sendCmd(3'd0, 24'h015000, 1'b0, 1'b0, "R2 read in window");
    sendCmd(3'd1, 24'h150000, 1'b0, 1'b0, "R2 disabled window");

    // R7 sticky flag
    cfgCheck("R7 flag set", 3'd7, 32'h1);
    cfgWrite(3'd7, 32'h0);
    cfgCheck("R7 write0 keeps", 3'd7, 32'h1);
    cfgWrite(3'd7, 32'h1);
    cfgCheck("R7 write1 clears", 3'd7, 32'h0);
    check("R7 port clear", {31'b0, blockedFlag}, 32'h0);

    // R3 global protect and override
    cfgWrite(3'd5, 32'h1);
    sendCmd(3'd2, 24'h300000, 1'b0, 1'b1, "R3 global write");
    sendCmd(3'd0, 24'h300000, 1'b0, 1'b0, "R3 global read");
    sendCmd(3'd2, 24'h300000, 1'b1, 1'b1, "R3 req without enable");
    cfgWrite(3'd5, 32'h3);
    sendCmd(3'd2, 24'h300000, 1'b1, 1'b0, "R3 override lifts");
    sendCmd(3'd2, 24'h300000, 1'b0, 1'b1, "R3 enable without req");
    sendCmd(3'd2, 24'h018000, 1'b1, 1'b1, "R5 window still refuses");
    cfgWrite(3'd5, 32'h0);

    // R4 shared window
    cfgWrite(3'd6, 32'h8040_F400);
    sendCmd(3'd0, 24'h400000, 1'b0, 1'b1, "R4 shared read");
    sendCmd(3'd3, 24'h40FFFF, 1'b0, 1'b1, "R4 shared read limit");
    sendCmd(3'd1, 24'h405000, 1'b0, 1'b1, "R4 shared write");
    sendCmd(3'd0, 24'h410000, 1'b0, 1'b0, "R4 outside shared");
    sendCmd(3'd1, 24'h500000, 1'b0, 1'b0, "R5 no source");

    // R7 refusal in the same cycle as a clear
    @(negedge clk);
    cmdValid = 1'b1; cmdOpIdx = 3'd1; cmdAddr = 24'h010000;
    expQ.push_back(1'b1); tagQ.push_back("R7 set vs clear");
    cfgWe = 1'b1; cfgAddr = 3'd7; cfgWdata = 32'h1;
    @(negedge clk);
    cmdValid = 1'b0; cfgWe = 1'b0;
    cfgCheck("R7 set beats clear", 3'd7, 32'h1);

    // R8 lock
    cfgWrite(3'd5, 32'h4);
    cfgWrite(3'd0, 32'h0);
    cfgCheck("R8 window locked", 3'd0, 32'h8001_F010);
    cfgWrite(3'd4, 32'h0);
    cfgCheck("R8 table locked", 3'd4, 32'h0000_0006);
    cfgWrite(3'd5, 32'h0);
    cfgCheck("R8 lock kept", 3'd5, 32'h4);
    sendCmd(3'd1, 24'h010000, 1'b0, 1'b1, "R8 policy kept");

    repeat (4) @(negedge clk);
    check("R6 all completed", expQ.size(), 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule